// File: doc/BRIEF.md
# NAND Page-Program Rule Checker

This block watches the control and data lines of a NAND flash device from the side and never drives them. It recognises page-program transactions and reports any that break the device's programming rules. A program transaction opens with the load command, carries five address bytes and at least one data byte, and closes with the confirm command. For every block the checker remembers the highest page that has been programmed. For every page it counts how many partial programs the page has taken since that block was last erased. It also watches for commands that are not allowed while the device is busy.

Each rule violation produces a one-cycle pulse on its own error line and sets a matching sticky bit. The sticky bits hold until a synchronous clear. An erase-completed input with a block number wipes that block's history. The page and block field widths and the partial-program limit are parameters, so a small configuration can be swept completely in simulation.

Top module: `nand_prog_monitor`

## Requirements
- R1: While reset is held and on the first cycle after it is released, `err_pulse` and `err_sticky` are all zero, and every block starts with no programmed page and zero partial counts.
- R2: A bus byte is taken only at a rising edge of `we_n`, which the block detects by sampling on `clk`. With `cle` high and `ale` low the byte is a command. With `ale` high and `cle` low it is an address. With both low it is data. A strobe with both `cle` and `ale` high is ignored.
- R3: Legal order is 80h, then exactly five address bytes, then one or more data bytes, then 10h. A sequence error (bit 3) is raised for each of these cases, and the transaction is dropped: a 10h outside the data phase, a 10h with no data byte, any command other than FFh in the middle of a transaction, a data byte before the fifth address, and an address byte in the data phase. FFh abandons a transaction without an error.
- R4: At a legal 10h, if the block already holds a programmed page with a higher index than the addressed page, an order error (bit 0) is raised. Programming the same page again, or a higher page, is accepted. Each block keeps its own pointer.
- R5: At a legal 10h whose page has already taken MAX_PARTIAL accepted programs since the last erase, a partial-count error (bit 1) is raised. Rejected programs change no pointer and no count. The order check takes priority over this check.
- R6: While `rb_n` is low, a command other than 70h or FFh raises a busy error (bit 2) and is otherwise ignored. 70h while busy has no effect.
- R7: A cycle with `erase_done` high clears the page pointer and all partial counts of block `erase_blk` only. Other blocks keep their history.
- R8: Each violation gives `err_pulse` one cycle high, on the cycle after the clock edge that detects the `we_n` rise. At most one pulse bit is high at a time. `err_sticky` keeps every pulsed bit until `err_clr`. A violation in the same cycle as `err_clr` stays set.
- R9: Address bytes 1 and 2 are column bytes and are ignored. Bytes 3, 4 and 5 form the row, with byte 3 as the least significant byte. The page is row bits [PAGE_W-1:0] and the block is the next BLK_W bits. Higher row bits are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cle | input | 1 | Command latch enable from the bus |
| ale | input | 1 | Address latch enable from the bus |
| we_n | input | 1 | Write strobe from the bus, bytes taken on its rise |
| io | input | 8 | Bus data byte |
| rb_n | input | 1 | Ready/busy from the device, low while busy |
| erase_done | input | 1 | Block erase completed, one cycle |
| erase_blk | input | BLK_W | Block that was erased |
| err_clr | input | 1 | Synchronous clear of the sticky error bits |
| err_pulse | output | 4 | One-cycle error events: bit 0 order, 1 partial, 2 busy, 3 sequence |
| err_sticky | output | 4 | Held error bits, same encoding |

## Verification
The bound assertions check the cycle-level rules on every cycle. These are: pulses follow only strobe edges, at most one pulse is high at once, sticky bits follow the pulses and clear on request, a busy-window command with a forbidden code always flags, and order and partial errors appear only after a confirm. The history rules can only be shown by the bench's scenarios. These are: per-block page ordering, the fifth partial program, the wipe of a single block on erase, that rejected confirms leave the counts unchanged, and the row-byte decode. The bench's scenarios also show that a transaction really was dropped after a busy command or an FFh abort.

// File: rtl/nand_mon_pkg.sv
`timescale 1ns/1ps
package nand_mon_pkg;
  localparam logic [7:0] OP_LOAD   = 8'h80;
  localparam logic [7:0] OP_COMMIT = 8'h10;
  localparam logic [7:0] OP_STATUS = 8'h70;
  localparam logic [7:0] OP_ABORT  = 8'hFF;

  localparam int ADDR_BYTES = 5;
  localparam int COL_BYTES  = 2;

  localparam int ERR_ORDER   = 0;
  localparam int ERR_PARTIAL = 1;
  localparam int ERR_BUSY    = 2;
  localparam int ERR_SEQ     = 3;
  localparam int ERR_N       = 4;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ADDR = 2'd1,
    PH_DATA = 2'd2
  } phase_t;

  // Commands tolerated while the device is busy
  function automatic logic busy_ok(input logic [7:0] op);
    return (op == OP_STATUS) || (op == OP_ABORT);
  endfunction
endpackage

// File: rtl/nand_bus_decoder.sv
`timescale 1ns/1ps
module nand_bus_decoder (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cle,
  input  logic       ale,
  input  logic       we_n,
  output logic       strobe,
  output logic       cmd_ev,
  output logic       addr_ev,
  output logic       data_ev
);
  logic we_q;

  always_ff @(posedge clk) begin
    if (!rst_n) we_q <= 1'b1;
    else        we_q <= we_n;
  end

  always_comb begin
    strobe  = we_n & ~we_q;
    cmd_ev  = strobe &  cle & ~ale;
    addr_ev = strobe & ~cle &  ale;
    data_ev = strobe & ~cle & ~ale;
  end
endmodule

// File: rtl/nand_seq_fsm.sv
`timescale 1ns/1ps
module nand_seq_fsm
  import nand_mon_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_ev,
  input  logic        addr_ev,
  input  logic        data_ev,
  input  logic [7:0]  io,
  input  logic        rb_n,
  output logic        seq_ev,
  output logic        busy_ev,
  output logic        confirm_ev,
  output logic [23:0] row
);
  phase_t      ph_q, ph_n;
  logic [2:0]  acnt_q, acnt_n;
  logic [23:0] row_q, row_n;
  logic        got_data_q, got_data_n;

  always_comb begin
    ph_n       = ph_q;
    acnt_n     = acnt_q;
    row_n      = row_q;
    got_data_n = got_data_q;
    seq_ev     = 1'b0;
    busy_ev    = 1'b0;
    confirm_ev = 1'b0;
    if (cmd_ev) begin
      if (!rb_n && !busy_ok(io)) begin
        busy_ev = 1'b1;
      end else if (io == OP_ABORT) begin
        ph_n = PH_IDLE;
      end else if (!rb_n) begin
        // status poll while busy: no effect
      end else begin
        unique case (ph_q)
          PH_IDLE: begin
            if (io == OP_LOAD) begin
              ph_n       = PH_ADDR;
              acnt_n     = 3'd0;
              got_data_n = 1'b0;
            end else if (io == OP_COMMIT) begin
              seq_ev = 1'b1;
            end
          end
          PH_ADDR: begin
            seq_ev = 1'b1;
            ph_n   = PH_IDLE;
          end
          PH_DATA: begin
            if (io == OP_COMMIT && got_data_q) confirm_ev = 1'b1;
            else                               seq_ev     = 1'b1;
            ph_n = PH_IDLE;
          end
          default: ph_n = PH_IDLE;
        endcase
      end
    end else if (addr_ev) begin
      unique case (ph_q)
        PH_ADDR: begin
          unique case (acnt_q)
            3'd2:    row_n[7:0]   = io;
            3'd3:    row_n[15:8]  = io;
            3'd4:    row_n[23:16] = io;
            default: ;
          endcase
          acnt_n = acnt_q + 3'd1;
          if (acnt_q == 3'(ADDR_BYTES - 1)) ph_n = PH_DATA;
        end
        PH_DATA: begin
          seq_ev = 1'b1;
          ph_n   = PH_IDLE;
        end
        default: ;
      endcase
    end else if (data_ev) begin
      unique case (ph_q)
        PH_ADDR: begin
          seq_ev = 1'b1;
          ph_n   = PH_IDLE;
        end
        PH_DATA: got_data_n = 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph_q       <= PH_IDLE;
      acnt_q     <= 3'd0;
      row_q      <= 24'd0;
      got_data_q <= 1'b0;
    end else begin
      ph_q       <= ph_n;
      acnt_q     <= acnt_n;
      row_q      <= row_n;
      got_data_q <= got_data_n;
    end
  end

  assign row = row_q;
endmodule

// File: rtl/nand_page_tracker.sv
`timescale 1ns/1ps
module nand_page_tracker #(
  parameter int PAGE_W      = 6,
  parameter int BLK_W       = 3,
  parameter int MAX_PARTIAL = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              confirm_ev,
  input  logic [23:0]       row,
  input  logic              erase_done,
  input  logic [BLK_W-1:0]  erase_blk,
  output logic              order_ev,
  output logic              partial_ev
);
  localparam int NBLK  = 1 << BLK_W;
  localparam int NPG   = 1 << PAGE_W;
  localparam int CNT_W = $clog2(MAX_PARTIAL + 1);
  localparam int ROW_W = PAGE_W + BLK_W;

  function automatic logic [PAGE_W-1:0] page_of(input logic [23:0] r);
    return r[PAGE_W-1:0];
  endfunction

  function automatic logic [BLK_W-1:0] block_of(input logic [23:0] r);
    return r[PAGE_W +: BLK_W];
  endfunction

  logic [NBLK-1:0][PAGE_W-1:0]    last_all;
  logic [NBLK-1:0]                vld_all;
  logic [NBLK*NPG-1:0][CNT_W-1:0] cnt_all;

  logic [PAGE_W-1:0] pg;
  logic [BLK_W-1:0]  blk;
  logic [CNT_W-1:0]  cur_cnt;
  logic              order_bad, full, accept;
  logic              unused_row_hi;

  assign unused_row_hi = ^row[23:ROW_W];

  always_comb begin
    pg         = page_of(row);
    blk        = block_of(row);
    cur_cnt    = cnt_all[{blk, pg}];
    order_bad  = vld_all[blk] && (pg < last_all[blk]);
    full       = cur_cnt >= CNT_W'(MAX_PARTIAL);
    order_ev   = confirm_ev & order_bad;
    partial_ev = confirm_ev & ~order_bad & full;
    accept     = confirm_ev & ~order_bad & ~full;
  end

  for (genvar b = 0; b < NBLK; b++) begin : g_blk
    logic              hit, wipe, vld_q;
    logic [PAGE_W-1:0] last_q;

    assign hit  = accept && (blk == BLK_W'(b));
    assign wipe = erase_done && (erase_blk == BLK_W'(b));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        vld_q  <= 1'b0;
        last_q <= '0;
      end else if (wipe) begin
        vld_q  <= 1'b0;
        last_q <= '0;
      end else if (hit) begin
        vld_q  <= 1'b1;
        last_q <= pg;
      end
    end

    assign vld_all[b]  = vld_q;
    assign last_all[b] = last_q;

    for (genvar p = 0; p < NPG; p++) begin : g_pg
      logic [CNT_W-1:0] cnt_q;
      always_ff @(posedge clk) begin
        if (!rst_n)                          cnt_q <= '0;
        else if (wipe)                       cnt_q <= '0;
        else if (hit && pg == PAGE_W'(p))    cnt_q <= cnt_q + CNT_W'(1);
      end
      assign cnt_all[b*NPG + p] = cnt_q;
    end
  end
endmodule

// File: rtl/nand_err_collect.sv
`timescale 1ns/1ps
module nand_err_collect #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         err_clr,
  input  logic [N-1:0] ev,
  output logic [N-1:0] pulse,
  output logic [N-1:0] sticky
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pulse  <= '0;
      sticky <= '0;
    end else begin
      pulse  <= ev;
      sticky <= err_clr ? ev : (sticky | ev);
    end
  end
endmodule

// File: rtl/nand_prog_monitor.sv
`timescale 1ns/1ps
module nand_prog_monitor
  import nand_mon_pkg::*;
#(
  parameter int PAGE_W      = 6,
  parameter int BLK_W       = 3,
  parameter int MAX_PARTIAL = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cle,
  input  logic             ale,
  input  logic             we_n,
  input  logic [7:0]       io,
  input  logic             rb_n,
  input  logic             erase_done,
  input  logic [BLK_W-1:0] erase_blk,
  input  logic             err_clr,
  output logic [3:0]       err_pulse,
  output logic [3:0]       err_sticky
);
  logic        wr_evt, cmd_ev, addr_ev, data_ev;
  logic        seq_ev, busy_ev, confirm_ev, order_ev, partial_ev;
  logic [23:0] row;
  logic [ERR_N-1:0] ev_vec;

  nand_bus_decoder u_dec (
    .clk(clk), .rst_n(rst_n), .cle(cle), .ale(ale), .we_n(we_n),
    .strobe(wr_evt), .cmd_ev(cmd_ev), .addr_ev(addr_ev), .data_ev(data_ev)
  );

  nand_seq_fsm u_seq (
    .clk(clk), .rst_n(rst_n), .cmd_ev(cmd_ev), .addr_ev(addr_ev),
    .data_ev(data_ev), .io(io), .rb_n(rb_n), .seq_ev(seq_ev),
    .busy_ev(busy_ev), .confirm_ev(confirm_ev), .row(row)
  );

  nand_page_tracker #(.PAGE_W(PAGE_W), .BLK_W(BLK_W), .MAX_PARTIAL(MAX_PARTIAL)) u_trk (
    .clk(clk), .rst_n(rst_n), .confirm_ev(confirm_ev), .row(row),
    .erase_done(erase_done), .erase_blk(erase_blk),
    .order_ev(order_ev), .partial_ev(partial_ev)
  );

  always_comb begin
    ev_vec              = '0;
    ev_vec[ERR_ORDER]   = order_ev;
    ev_vec[ERR_PARTIAL] = partial_ev;
    ev_vec[ERR_BUSY]    = busy_ev;
    ev_vec[ERR_SEQ]     = seq_ev;
  end

  nand_err_collect #(.N(ERR_N)) u_err (
    .clk(clk), .rst_n(rst_n), .err_clr(err_clr), .ev(ev_vec),
    .pulse(err_pulse), .sticky(err_sticky)
  );
endmodule

// File: rtl/nand_prog_monitor_chk.sv
`timescale 1ns/1ps
module nand_prog_monitor_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cle,
  input logic       ale,
  input logic [7:0] io,
  input logic       rb_n,
  input logic       err_clr,
  input logic       wr_evt,
  input logic       confirm_ev,
  input logic [3:0] ev_vec,
  input logic [3:0] err_pulse,
  input logic [3:0] err_sticky
);
  assert_reset_quiet_R1: assert property (@(posedge clk)
    $rose(rst_n) |-> (err_pulse == 4'd0 && err_sticky == 4'd0));

  assert_pulse_from_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (|err_pulse) |-> $past(wr_evt));

  assert_order_on_confirm_R4: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse[0] |-> $past(confirm_ev));

  assert_partial_on_confirm_R5: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse[1] |-> $past(confirm_ev));

  assert_busy_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_evt && cle && !ale && !rb_n && io != 8'h70 && io != 8'hFF) |=> err_pulse[2]);

  assert_single_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(err_pulse));

  assert_pulse_sets_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((err_pulse & err_sticky) == err_pulse));

  assert_sticky_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !err_clr |=> ((err_sticky & $past(err_sticky)) == $past(err_sticky)));

  assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (err_clr && ev_vec == 4'd0) |=> (err_sticky == 4'd0));
endmodule

bind nand_prog_monitor nand_prog_monitor_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cle(cle), .ale(ale), .io(io), .rb_n(rb_n),
  .err_clr(err_clr), .wr_evt(wr_evt), .confirm_ev(confirm_ev),
  .ev_vec(ev_vec), .err_pulse(err_pulse), .err_sticky(err_sticky)
);

// File: tb/sim_nand_prog_monitor.sv
`timescale 1ns/1ps
module sim_nand_prog_monitor;
  localparam int PW = 2;
  localparam int BW = 2;
  localparam int MP = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cle = 1'b0, ale = 1'b0, we_n = 1'b1, rb_n = 1'b1;
  logic [7:0]    io = 8'h00;
  logic          erase_done = 1'b0, err_clr = 1'b0;
  logic [BW-1:0] erase_blk = '0;
  logic [3:0]    err_pulse, err_sticky;

  int tests = 0, fails = 0;
  logic [3:0] exp_q[$];
  string      tag_q[$];
  logic [3:0] exp_sticky = 4'd0;
  logic       we_prev = 1'b1;

  localparam logic [3:0] E_NONE = 4'b0000, E_ORD = 4'b0001, E_PAR = 4'b0010,
                         E_BSY = 4'b0100, E_SEQ = 4'b1000;

  always #10 clk = ~clk;

  nand_prog_monitor #(.PAGE_W(PW), .BLK_W(BW), .MAX_PARTIAL(MP)) u0 (
    .clk(clk), .rst_n(rst_n), .cle(cle), .ale(ale), .we_n(we_n), .io(io),
    .rb_n(rb_n), .erase_done(erase_done), .erase_blk(erase_blk),
    .err_clr(err_clr), .err_pulse(err_pulse), .err_sticky(err_sticky)
  );

  task automatic chk(input logic [3:0] act, input logic [3:0] exp, input string tag);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b", tag, act, exp);
    end
  endtask

  // Monitor: pops one expected pulse vector per we_n rise
  initial begin
    forever begin
      @(posedge clk);
      if (we_n && !we_prev) begin
        we_prev = we_n;
        @(negedge clk);
        if (exp_q.size() == 0) begin
          tests++; fails++;
          $display("FAIL R8: pulse %b with no expected item, expected none", err_pulse);
        end else begin
          chk(err_pulse, exp_q.pop_front(), tag_q.pop_front());
        end
      end else begin
        we_prev = we_n;
      end
    end
  end

  // Driver: one bus byte, expected pulse pushed to the scoreboard
  task automatic strobe(input logic c, input logic a, input logic [7:0] d,
                        input logic [3:0] exp, input string tag);
    @(negedge clk);
    cle = c; ale = a; io = d; we_n = 1'b0;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    exp_sticky = exp_sticky | exp;
    @(negedge clk);
    we_n = 1'b1;
  endtask

  task automatic addr5(input int b, input int p, input logic [7:0] col,
                       input logic [7:0] hi, input string tag);
    logic [7:0] r0;
    r0 = 8'((b << PW) | p);
    strobe(0, 1, col, E_NONE, tag);
    strobe(0, 1, col, E_NONE, tag);
    strobe(0, 1, r0,  E_NONE, tag);
    strobe(0, 1, hi,  E_NONE, tag);
    strobe(0, 1, hi,  E_NONE, tag);
  endtask

  task automatic prog(input int b, input int p, input logic [3:0] exp, input string tag,
                      input logic [7:0] col = 8'h00, input logic [7:0] hi = 8'h00);
    strobe(1, 0, 8'h80, E_NONE, tag);
    addr5(b, p, col, hi, tag);
    strobe(0, 0, 8'hA5, E_NONE, tag);
    strobe(0, 0, 8'h5A, E_NONE, tag);
    strobe(1, 0, 8'h10, exp, tag);
  endtask

  task automatic settle();
    @(negedge clk);
  endtask

  task automatic set_rb(input logic v);
    @(negedge clk);
    rb_n = v;
  endtask

  task automatic erase(input int b);
    @(negedge clk);
    erase_done = 1'b1; erase_blk = BW'(b);
    @(negedge clk);
    erase_done = 1'b0;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    chk(err_pulse, 4'd0, "R1 pulse in reset");
    chk(err_sticky, 4'd0, "R1 sticky in reset");
    rst_n = 1'b1;
    @(negedge clk);
    chk(err_sticky, 4'd0, "R1 sticky after reset");

    // R4: ascending order per block
    prog(0, 0, E_NONE, "R4 b0p0");
    prog(0, 1, E_NONE, "R4 b0p1");
    prog(0, 3, E_NONE, "R4 b0p3 skip ahead");
    prog(0, 2, E_ORD,  "R4 b0p2 below pointer");
    prog(0, 3, E_NONE, "R4 b0p3 same page again");
    prog(1, 0, E_NONE, "R4 b1p0 other block");
    settle();
    chk(err_sticky, exp_sticky, "R8 sticky after order error");
    @(negedge clk);
    chk(err_pulse, 4'd0, "R8 pulse lasts one cycle");

    // R5: partial-program limit
    for (int i = 0; i < MP; i++) prog(2, 1, E_NONE, "R5 partial within limit");
    prog(2, 1, E_PAR,  "R5 fifth partial");
    prog(2, 1, E_PAR,  "R5 rejected not counted");
    prog(2, 2, E_NONE, "R5 fresh page");

    // R7: erase clears one block only
    erase(2);
    prog(2, 0, E_NONE, "R7 pointer cleared");
    for (int i = 0; i < MP; i++) prog(2, 1, E_NONE, "R7 count cleared");
    prog(0, 1, E_ORD,  "R7 other block kept");

    // R3: sequence rules
    strobe(1, 0, 8'h10, E_SEQ, "R3 confirm while idle");
    strobe(1, 0, 8'h80, E_NONE, "R3 load");
    strobe(0, 1, 8'h00, E_NONE, "R3 addr");
    strobe(0, 1, 8'h00, E_NONE, "R3 addr");
    strobe(0, 1, 8'h00, E_NONE, "R3 addr");
    strobe(1, 0, 8'h10, E_SEQ, "R3 confirm after three addresses");
    strobe(1, 0, 8'h80, E_NONE, "R3 load");
    strobe(0, 1, 8'h00, E_NONE, "R3 addr");
    strobe(0, 1, 8'h00, E_NONE, "R3 addr");
    strobe(0, 0, 8'h11, E_SEQ, "R3 data before fifth address");
    strobe(1, 0, 8'h80, E_NONE, "R3 load");
    addr5(1, 1, 8'h00, 8'h00, "R3 addr");
    strobe(1, 0, 8'h10, E_SEQ, "R3 confirm without data");
    strobe(1, 0, 8'h80, E_NONE, "R3 load");
    addr5(1, 1, 8'h00, 8'h00, "R3 addr");
    strobe(0, 0, 8'h22, E_NONE, "R3 data");
    strobe(0, 1, 8'h00, E_SEQ, "R3 address in data phase");
    strobe(1, 0, 8'h80, E_NONE, "R3 load");
    addr5(1, 1, 8'h00, 8'h00, "R3 addr");
    strobe(0, 0, 8'h22, E_NONE, "R3 data");
    strobe(1, 0, 8'h80, E_SEQ, "R3 load inside transaction");
    strobe(1, 0, 8'h80, E_NONE, "R3 load");
    strobe(0, 1, 8'h00, E_NONE, "R3 addr");
    strobe(1, 0, 8'hFF, E_NONE, "R3 abort is silent");
    strobe(1, 0, 8'h10, E_SEQ, "R3 confirm after abort");

    // R2: strobe with both latches high ignored
    strobe(1, 1, 8'h10, E_NONE, "R2 cle and ale both high");

    // R6: commands while busy
    set_rb(1'b0);
    strobe(1, 0, 8'h00, E_BSY, "R6 read command while busy");
    strobe(1, 0, 8'h80, E_BSY, "R6 load while busy");
    strobe(1, 0, 8'h70, E_NONE, "R6 status while busy");
    set_rb(1'b1);
    strobe(1, 0, 8'h10, E_SEQ, "R6 busy load was ignored");
    strobe(1, 0, 8'h80, E_NONE, "R6 load");
    addr5(3, 0, 8'h00, 8'h00, "R6 addr");
    strobe(0, 0, 8'h33, E_NONE, "R6 data");
    set_rb(1'b0);
    strobe(1, 0, 8'h70, E_NONE, "R6 status poll mid transaction");
    set_rb(1'b1);
    strobe(1, 0, 8'h10, E_NONE, "R6 transaction survives poll");

    // R9: row decode, column and high row bytes ignored
    prog(3, 1, E_NONE, "R9 b3p1 noisy column and high row", 8'hFF, 8'hAA);
    prog(3, 0, E_ORD,  "R9 b3p0 below decoded pointer");
    settle();
    chk(err_sticky, exp_sticky, "R8 all sticky bits");

    // R8: clear, then clear together with an event
    @(negedge clk);
    err_clr = 1'b1;
    @(negedge clk);
    err_clr = 1'b0;
    exp_sticky = 4'd0;
    chk(err_sticky, 4'd0, "R8 sticky cleared");
    @(negedge clk);
    cle = 1'b1; ale = 1'b0; io = 8'h10; we_n = 1'b0;
    exp_q.push_back(E_SEQ);
    tag_q.push_back("R8 event with clear");
    @(negedge clk);
    we_n = 1'b1; err_clr = 1'b1;
    @(negedge clk);
    err_clr = 1'b0;
    chk(err_sticky, E_SEQ, "R8 event wins over clear");

    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) begin
      tests++; fails++;
      $display("FAIL R8: %0d expected pulses never seen, expected 0", exp_q.size());
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: run hung, got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule